// File: doc/BRIEF.md
# Segmented Converter Switch Decoder with Spare-Cell Substitution

This block turns a 14-bit sample code into the switch-control word for a current-steering converter that is built from three segments. The top six bits select how many of 63 unary coarse cells are on. The middle four bits select how many of 15 unary mid cells are on. The bottom four bits drive four binary-weighted fine switches directly. A 64th coarse cell is always on, because it supplies the current for the whole fine section.

A background calibrator takes one coarse cell at a time off the output to measure it. It names that cell with an index and raises an active flag. While the flag is high, the named cell is switched off and a spare cell carries the data bit that the named cell would have carried, so the converted signal never stops. The calibration controls are registered together with the code. All true/complement switch pairs then leave through one final register, so every switch in the word changes on the same clock edge.

Top module: `seg_dac_switch_decoder`

## Requirements
- R1: With field N = code[13:8], coarse outputs msb_p[i] for i in 0..62 are on exactly when i < N, unless cell i is under calibration.
- R2: msb_p[63], the cell that supplies the fine section, is on in every cycle except while cell 63 is under calibration.
- R3: With field M = code[7:4], mid outputs ulsb_p[j] for j in 0..14 are on exactly when j < M, so they always form a thermometer pattern.
- R4: Fine outputs llsb_p[3:0] equal code[3:0], with bit b of llsb_p taken from bit b of the code.
- R5: Every output reflects the code presented two rising edges earlier, and all three segments change on the same edge.
- R6: While cal_act is high with cal_sel = k < 63, msb_p[k] is off and spare_p equals the value cell k would have had by R1.
- R7: While cal_act is low, spare_p is off.
- R8: While cal_act is high with cal_sel = 63, msb_p[63] is off and spare_p is on, whatever the code.
- R9: Each _n output is the bitwise complement of its _p output in every cycle, including during reset.
- R10: cal_act and cal_sel are captured on the same edge as the code they accompany, so a substitution takes effect with the same 2-cycle latency as the data.
- R11: While rst_n is low, every _p output is 0 and every _n output is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| code | input | 14 | Sample code to convert |
| cal_act | input | 1 | High while a coarse cell is taken away for measurement |
| cal_sel | input | 6 | Index of the coarse cell under measurement (63 is the fine-section supply cell) |
| msb_p | output | 64 | Coarse cell switch controls, true side |
| msb_n | output | 64 | Coarse cell switch controls, complement side |
| ulsb_p | output | 15 | Mid cell switch controls, true side |
| ulsb_n | output | 15 | Mid cell switch controls, complement side |
| llsb_p | output | 4 | Binary fine switch controls, true side |
| llsb_n | output | 4 | Binary fine switch controls, complement side |
| spare_p | output | 1 | Spare cell switch control, true side |
| spare_n | output | 1 | Spare cell switch control, complement side |

## Verification
A new code and a change of the calibration index or flag can arrive in the same cycle. The substitution must then act on the new code's bit for the new cell, not on a mix of old and new. Directed steps change code, cal_sel and cal_act together: they move the index across cells just below, at and above the coarse count, and onto cell 63 with the code at zero and at full scale. Random steps also change all three freely. Each output cycle is compared, segment by segment, against a model applied to the inputs from two cycles before, so any skew between the data path and the calibration path shows up as a mismatch in the coarse or spare field.

// File: rtl/seg_dac_switch_decoder.sv
module seg_dac_switch_decoder #(
  parameter int MSB_BITS  = 6,
  parameter int ULSB_BITS = 4,
  parameter int LLSB_BITS = 4,
  localparam int CODE_W = MSB_BITS + ULSB_BITS + LLSB_BITS,
  localparam int NCELL  = 1 << MSB_BITS,
  localparam int NUL    = (1 << ULSB_BITS) - 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [CODE_W-1:0]    code,
  input  logic                 cal_act,
  input  logic [MSB_BITS-1:0]  cal_sel,
  output logic [NCELL-1:0]     msb_p,
  output logic [NCELL-1:0]     msb_n,
  output logic [NUL-1:0]       ulsb_p,
  output logic [NUL-1:0]       ulsb_n,
  output logic [LLSB_BITS-1:0] llsb_p,
  output logic [LLSB_BITS-1:0] llsb_n,
  output logic                 spare_p,
  output logic                 spare_n
);

  logic [CODE_W-1:0]   code_q;
  logic                act_q;
  logic [MSB_BITS-1:0] sel_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
      act_q  <= 1'b0;
      sel_q  <= '0;
    end else begin
      code_q <= code;
      act_q  <= cal_act;
      sel_q  <= cal_sel;
    end
  end

  wire [MSB_BITS-1:0]  mfield = code_q[CODE_W-1 -: MSB_BITS];
  wire [ULSB_BITS-1:0] ufield = code_q[LLSB_BITS +: ULSB_BITS];
  wire [LLSB_BITS-1:0] lfield = code_q[LLSB_BITS-1:0];

  logic [NCELL-1:0] logical;
  logic [NCELL-1:0] routed;
  logic [NUL-1:0]   uth;
  wire              spare_d = act_q & logical[sel_q];

  for (genvar i = 0; i < NCELL; i++) begin : g_msb
    localparam logic [MSB_BITS-1:0] IDX = MSB_BITS'(i);
    if (i == NCELL - 1) begin : g_supply
      assign logical[i] = 1'b1;
    end else begin : g_data
      assign logical[i] = mfield > IDX;
    end
    assign routed[i] = logical[i] & ~(act_q && sel_q == IDX);
  end

  for (genvar j = 0; j < NUL; j++) begin : g_ulsb
    localparam logic [ULSB_BITS-1:0] JDX = ULSB_BITS'(j);
    assign uth[j] = ufield > JDX;
  end

  logic [NCELL-1:0]     msb_q;
  logic [NUL-1:0]       ulsb_q;
  logic [LLSB_BITS-1:0] llsb_q;
  logic                 spare_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      msb_q   <= '0;
      ulsb_q  <= '0;
      llsb_q  <= '0;
      spare_q <= 1'b0;
    end else begin
      msb_q   <= routed;
      ulsb_q  <= uth;
      llsb_q  <= lfield;
      spare_q <= spare_d;
    end
  end

  assign msb_p   = msb_q;
  assign msb_n   = ~msb_q;
  assign ulsb_p  = ulsb_q;
  assign ulsb_n  = ~ulsb_q;
  assign llsb_p  = llsb_q;
  assign llsb_n  = ~llsb_q;
  assign spare_p = spare_q;
  assign spare_n = ~spare_q;

endmodule

// File: rtl/seg_dac_switch_decoder_chk.sv
module seg_dac_switch_decoder_chk #(
  parameter int MSB_BITS  = 6,
  parameter int ULSB_BITS = 4,
  parameter int LLSB_BITS = 4,
  localparam int CODE_W = MSB_BITS + ULSB_BITS + LLSB_BITS,
  localparam int NCELL  = 1 << MSB_BITS,
  localparam int NUL    = (1 << ULSB_BITS) - 1
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [CODE_W-1:0]    code,
  input logic                 cal_act,
  input logic [MSB_BITS-1:0]  cal_sel,
  input logic [NCELL-1:0]     msb_p,
  input logic [NCELL-1:0]     msb_n,
  input logic [NUL-1:0]       ulsb_p,
  input logic [NUL-1:0]       ulsb_n,
  input logic [LLSB_BITS-1:0] llsb_p,
  input logic [LLSB_BITS-1:0] llsb_n,
  input logic                 spare_p,
  input logic                 spare_n
);

  localparam logic [MSB_BITS-1:0] TOP = MSB_BITS'(NCELL - 1);

  logic [1:0] age;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) age <= 2'd0;
    else if (age != 2'd3) age <= age + 2'd1;
  end
  wire warm = age >= 2'd2;

  AST_MSB_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    warm |-> int'($countones(msb_p[NCELL-2:0])) + int'(spare_p && $past(cal_sel, 2) != TOP)
             == int'($past(code[CODE_W-1 -: MSB_BITS], 2)));  // R1
  AST_SUPPLY_ON: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && !($past(cal_act, 2) && $past(cal_sel, 2) == TOP)) |-> msb_p[NCELL-1]);  // R2
  AST_ULSB_THERM: assert property (@(posedge clk) disable iff (!rst_n)
    warm |-> (((ulsb_p + NUL'(1)) & ulsb_p) == '0)
             && int'($countones(ulsb_p)) == int'($past(code[LLSB_BITS +: ULSB_BITS], 2)));  // R3
  AST_LLSB_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    warm |-> llsb_p == $past(code[LLSB_BITS-1:0], 2));  // R4
  AST_CAL_CELL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && $past(cal_act, 2)) |-> !msb_p[$past(cal_sel, 2)]);  // R6
  AST_SPARE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && !$past(cal_act, 2)) |-> !spare_p);  // R7
  AST_SPARE_SUPPLY: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && $past(cal_act, 2) && $past(cal_sel, 2) == TOP) |-> spare_p);  // R8
  AST_DIFF_PAIRS: assert property (@(posedge clk)
    (&(msb_p ^ msb_n)) && (&(ulsb_p ^ ulsb_n)) && (&(llsb_p ^ llsb_n)) && (spare_p ^ spare_n));  // R9
  AST_RESET_CLEAR: assert property (@(posedge clk)
    !rst_n |-> msb_p == '0 && ulsb_p == '0 && llsb_p == '0 && !spare_p);  // R11

endmodule

bind seg_dac_switch_decoder seg_dac_switch_decoder_chk #(
  .MSB_BITS(MSB_BITS), .ULSB_BITS(ULSB_BITS), .LLSB_BITS(LLSB_BITS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .code(code), .cal_act(cal_act), .cal_sel(cal_sel),
  .msb_p(msb_p), .msb_n(msb_n), .ulsb_p(ulsb_p), .ulsb_n(ulsb_n),
  .llsb_p(llsb_p), .llsb_n(llsb_n), .spare_p(spare_p), .spare_n(spare_n)
);

// File: tb/sim_seg_dac_switch_decoder.sv
`timescale 1ns/1ps
module sim_seg_dac_switch_decoder;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [13:0] code = '0;
  logic        cal_act = 1'b0;
  logic [5:0]  cal_sel = '0;
  logic [63:0] msb_p, msb_n;
  logic [14:0] ulsb_p, ulsb_n;
  logic [3:0]  llsb_p, llsb_n;
  logic        spare_p, spare_n;

  always #2 clk = ~clk;

  seg_dac_switch_decoder u0 (
    .clk(clk), .rst_n(rst_n), .code(code), .cal_act(cal_act), .cal_sel(cal_sel),
    .msb_p(msb_p), .msb_n(msb_n), .ulsb_p(ulsb_p), .ulsb_n(ulsb_n),
    .llsb_p(llsb_p), .llsb_n(llsb_n), .spare_p(spare_p), .spare_n(spare_n)
  );

  int checks = 0;
  int fails  = 0;
  int warm   = 0;
  bit done   = 0;
  logic [13:0] h0_code, h1_code;
  logic        h0_act, h1_act;
  logic [5:0]  h0_sel, h1_sel;

  function automatic logic [63:0] exp_msb(logic [13:0] c, logic a, logic [5:0] s);
    logic [63:0] r;
    for (int i = 0; i < 63; i++) r[i] = (i < int'(c[13:8]));
    r[63] = 1'b1;
    if (a) r[s] = 1'b0;
    return r;
  endfunction

  function automatic logic [14:0] exp_ulsb(logic [13:0] c);
    logic [14:0] r;
    for (int j = 0; j < 15; j++) r[j] = (j < int'(c[7:4]));
    return r;
  endfunction

  function automatic logic exp_spare(logic [13:0] c, logic a, logic [5:0] s);
    if (!a) return 1'b0;
    if (s == 6'd63) return 1'b1;
    return int'(s) < int'(c[13:8]);
  endfunction

  task automatic check(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic compare_all(logic [13:0] c, logic a, logic [5:0] s);
    logic [63:0] em;
    em = exp_msb(c, a, s);
    if (a && s == 6'd63)
      check(msb_p === em, "R8 coarse with supply cell under test", msb_p, em);
    else if (a)
      check(msb_p === em, "R6/R10 coarse with cell under test", msb_p, em);
    else
      check(msb_p === em, "R1/R2/R5 coarse thermometer", msb_p, em);
    check(ulsb_p === exp_ulsb(c), "R3/R5 mid thermometer", 64'(ulsb_p), 64'(exp_ulsb(c)));
    check(llsb_p === c[3:0], "R4/R5 fine binary", 64'(llsb_p), 64'(c[3:0]));
    if (a && s == 6'd63)
      check(spare_p === 1'b1, "R8 spare for supply cell", 64'(spare_p), 64'(1));
    else if (a)
      check(spare_p === exp_spare(c, a, s), "R6/R10 spare carries cell bit", 64'(spare_p), 64'(exp_spare(c, a, s)));
    else
      check(spare_p === 1'b0, "R7 spare idle", 64'(spare_p), 64'(0));
    check(msb_n === ~msb_p && ulsb_n === ~ulsb_p && llsb_n === ~llsb_p && spare_n === ~spare_p,
          "R9 complement pairs", 64'(msb_n), ~msb_p);
  endtask

  task automatic step(logic [13:0] c, logic a, logic [5:0] s);
    @(negedge clk);
    if (warm >= 2) compare_all(h1_code, h1_act, h1_sel);
    h1_code = h0_code; h1_act = h0_act; h1_sel = h0_sel;
    h0_code = c; h0_act = a; h0_sel = s;
    code = c; cal_act = a; cal_sel = s;
    warm++;
  endtask

  initial begin
    int seed;
    seed = 32'h5EED_0A17;
    void'($urandom(seed));
    code = 14'h3FFF; cal_act = 1'b1; cal_sel = 6'd5;
    repeat (3) @(negedge clk);
    check(msb_p === '0 && ulsb_p === '0 && llsb_p === '0 && spare_p === 1'b0,
          "R11 reset true side", msb_p, 64'(0));
    check(&msb_n && &ulsb_n && &llsb_n && spare_n, "R11/R9 reset complement side", msb_n, '1);
    rst_n = 1'b1;
    h0_code = code; h0_act = cal_act; h0_sel = cal_sel;
    warm = 1;
    step(14'h0000, 1'b0, 6'd0);
    step(14'h3FFF, 1'b0, 6'd0);
    step(14'h2A5C, 1'b0, 6'd0);
    step(14'h0000, 1'b1, 6'd63);
    step(14'h3FFF, 1'b1, 6'd63);
    step(14'h0000, 1'b1, 6'd0);
    step(14'h0100, 1'b1, 6'd0);
    step(14'h3FFF, 1'b1, 6'd62);
    step(14'h3EFF, 1'b1, 6'd62);
    step(14'h1F00, 1'b1, 6'd30);
    step(14'h1F00, 1'b1, 6'd31);
    step(14'h1F00, 1'b1, 6'd32);
    step(14'h0A00, 1'b0, 6'd9);
    step(14'h0AF0, 1'b1, 6'd9);
    step(14'h0AF0, 1'b0, 6'd9);
    for (int n = 0; n < 4000; n++) begin
      logic [31:0] r;
      r = $urandom;
      step(r[13:0], r[16] | r[17], (r[20:18] == 3'd0) ? 6'd63 : r[26:21]);
    end
    step(14'h0000, 1'b0, 6'd0);
    step(14'h0000, 1'b0, 6'd0);
    step(14'h0000, 1'b0, 6'd0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired before the run completed");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

endmodule